// File: doc/BRIEF.md
# Three-Wire Serial Memory Erase Front-End

This block is the device side of a three-wire serial memory (select, clock, data in) that handles only erase traffic for a 64-word by 16-bit store. The select, serial clock and data lines are asynchronous to the block. Each one passes through a two-stage synchroniser clocked by a fast system clock. A serial-clock rising edge counts only when select has already been seen high on the two previous system-clock samples. After select goes high, the block discards data bits of 0 until the first 1. That 1 is the start bit. The block then shifts in a 2-bit opcode and a 6-bit address, most significant bit first.

A frame that decodes to an erase is committed on its ninth counted clock edge. Before that edge, dropping select abandons the frame. After it, nothing cancels the erase, including further clock pulses. The erase takes place when select is next seen low. The write happens on the cycle that `busy` rises. `busy` then stays high for a parameterised number of system clocks, and the block ignores every frame during that time. Neighbouring logic reads the storage array through a direct combinational read port.

Top module: `mw_erase_fe`

## Requirements
- R1: After reset, `busy` is 0 and word i of the array holds i in both bytes ({2'b00,i,2'b00,i}).
- R2: Opcode 2'b11 (the two bits after the start bit) with address A sets word A to 16'hFFFF and leaves every other word unchanged.
- R3: Opcode 2'b00 with address bits [5:4] = 2'b10 sets all 64 words to 16'hFFFF, whatever the low address bits.
- R4: Opcodes 2'b01 and 2'b10, and opcode 2'b00 with address bits [5:4] other than 2'b10, change no word and never raise `busy`.
- R5: If select is seen low before the ninth counted clock edge, no word changes and `busy` stays low. This includes the case where the ninth edge and the select fall reach the block in the same system-clock cycle.
- R6: Once the ninth edge is counted, the erase is carried out even if more clock pulses follow before select falls.
- R7: After a committed frame, `busy` rises only after select has been seen low. It stays high for exactly ERASE_CLKS consecutive system clocks.
- R8: A complete erase frame sent while `busy` is high has no effect.
- R9: If select rises while the serial clock and data are already high, that clock level is not counted as a start-bit edge.
- R10: Data bits of 0 sent before the first 1 while select is high are not part of the frame.
- R11: While select is low, clock pulses and data bits change no word and raise no `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Serial select, asynchronous, high active |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| rd_addr | input | 6 | Word address for the direct read port |
| rd_data | output | 16 | Content of the addressed word (combinational) |
| busy | output | 1 | High while the internal erase cycle runs |

## Verification
Two events can reach the control logic in the same system-clock cycle: the ninth clock edge that would commit a frame, and the select fall that would cancel it. The bench provokes this by driving the serial clock high and select low on the same system-clock edge. Both then pass through matching synchronisers and arrive together. The expected result is a cancel: no word may change and `busy` must stay low. The same frame with select dropped a few clocks after the ninth edge is the contrasting case, and it must erase.

// File: rtl/mw_erase_fe.sv
module mw_erase_fe #(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int ERASE_CLKS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          sk_i,
  input  logic          di_i,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int WORDS = 1 << AW;
  localparam int FW    = AW + 2;
  localparam int CW    = $clog2(FW + 1);
  localparam int TW    = $clog2(ERASE_CLKS + 1);

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SHIFT  = 3'd1,
    S_COMMIT = 3'd2,
    S_DROP   = 3'd3,
    S_ERASE  = 3'd4
  } state_t;

  state_t          state;
  logic            cs_m, cs_s, cs_d;
  logic            sk_m, sk_s, sk_q;
  logic            di_m, di_s;
  logic [FW-1:0]   sr;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tmr;
  logic            all_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   mem [WORDS];

  logic            sk_rise;
  logic [FW-1:0]   frame_nx;
  logic [1:0]      op;
  logic [AW-1:0]   ad;
  logic            is_word, is_all, last;

  assign sk_rise  = cs_s & cs_d & sk_s & ~sk_q;
  assign frame_nx = {sr[FW-2:0], di_s};
  assign op       = frame_nx[FW-1 -: 2];
  assign ad       = frame_nx[AW-1:0];
  assign is_word  = (op == 2'b11);
  assign is_all   = (op == 2'b00) && (ad[AW-1 -: 2] == 2'b10);
  assign last     = (cnt == CW'(FW - 1));
  assign busy     = (state == S_ERASE);
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_m, cs_s, cs_d} <= '0;
      {sk_m, sk_s, sk_q} <= '0;
      {di_m, di_s}       <= '0;
    end else begin
      cs_m <= cs_i; cs_s <= cs_m; cs_d <= cs_s;
      sk_m <= sk_i; sk_s <= sk_m; sk_q <= sk_s;
      di_m <= di_i; di_s <= di_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sr     <= '0;
      cnt    <= '0;
      tmr    <= '0;
      all_q  <= 1'b0;
      addr_q <= '0;
      for (int i = 0; i < WORDS; i++)
        mem[i] <= DW'((i << (DW / 2)) | i);
    end else begin
      case (state)
        S_IDLE: begin
          if (sk_rise && di_s) begin
            state <= S_SHIFT;
            cnt   <= '0;
          end
        end
        S_SHIFT: begin
          if (!cs_s) begin
            state <= S_IDLE;
          end else if (sk_rise) begin
            sr  <= frame_nx;
            cnt <= cnt + 1'b1;
            if (last) begin
              if (is_word || is_all) begin
                state  <= S_COMMIT;
                all_q  <= is_all;
                addr_q <= ad;
              end else begin
                state <= S_DROP;
              end
            end
          end
        end
        S_COMMIT: begin
          if (!cs_s) begin
            state <= S_ERASE;
            tmr   <= '0;
            if (all_q) begin
              for (int i = 0; i < WORDS; i++) mem[i] <= '1;
            end else begin
              mem[addr_q] <= '1;
            end
          end
        end
        S_DROP: begin
          if (!cs_s) state <= S_IDLE;
        end
        S_ERASE: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(ERASE_CLKS - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_erase_fe_chk.sv
module mw_erase_fe_chk #(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int ERASE_CLKS = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cs_s,
  input logic [2:0]    st,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data
);
  localparam logic [2:0] C_IDLE   = 3'd0;
  localparam logic [2:0] C_SHIFT  = 3'd1;
  localparam logic [2:0] C_COMMIT = 3'd2;

  int bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < ERASE_CLKS);

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == ERASE_CLKS);

  // R7
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs_s));

  // R5
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_addr) && !$rose(busy)) |-> $stable(rd_data));

  // R6
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_COMMIT && cs_s) |=> st == C_COMMIT);

  // R11
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && !cs_s) |=> st != C_SHIFT);
endmodule

bind mw_erase_fe mw_erase_fe_chk #(.AW(AW), .DW(DW), .ERASE_CLKS(ERASE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_s(cs_s), .st(state),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/mw_erase_fe_tb.sv
module mw_erase_fe_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 1 << AW;
  localparam int EC = 150;
  localparam int H  = 4;

  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic busy;
  int checks = 0, errors = 0, busy_cnt = 0;
  logic [DW-1:0] model [N];
  bit done = 0;

  always #10 clk = ~clk;

  mw_erase_fe #(.AW(AW), .DW(DW), .ERASE_CLKS(EC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    logic [DW-1:0] got = '0;
    for (int a = 0; a < N; a++) begin
      rd_addr = AW'(a);
      #1;
      if (bad < 0 && rd_data !== model[a]) begin bad = a; got = rd_data; end
    end
    check(bad < 0, req, got, bad < 0 ? 0 : model[bad]);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; cs = 0; sk = 0; di = 0;
    settle(3);
    rst_n = 1;
    for (int a = 0; a < N; a++) model[a] = DW'((a << 8) | a);
    settle(2);
    busy_cnt = 0;
  endtask

  task automatic pulse(input logic d);
    di = d;
    settle(H);
    sk = 1;
    settle(H);
    sk = 0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [AW-1:0] ad, input int nedges);
    logic [8:0] bits = {1'b1, op, ad};
    for (int k = 0; k < nedges; k++) pulse(bits[8-k]);
  endtask

  task automatic cs_on();
    cs = 1; settle(H);
  endtask

  task automatic cs_off();
    settle(H); cs = 0; di = 0;
  endtask

  task automatic apply(input logic [1:0] op, input logic [AW-1:0] ad);
    if (op == 2'b11) model[ad] = '1;
    else if (op == 2'b00 && ad[5:4] == 2'b10)
      for (int a = 0; a < N; a++) model[a] = '1;
  endtask

  task automatic run(input logic [1:0] op, input logic [AW-1:0] ad, input int nedges,
                     input int extra, input string req);
    bit erase = (nedges == 9) && (op == 2'b11 || (op == 2'b00 && ad[5:4] == 2'b10));
    busy_cnt = 0;
    cs_on();
    frame(op, ad, nedges);
    for (int k = 0; k < extra; k++) pulse(k[0]);
    cs_off();
    settle(EC + 30);
    if (erase) apply(op, ad);
    check(busy_cnt == (erase ? EC : 0), req, busy_cnt, erase ? EC : 0);
    check_mem(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check(busy == 0, "R1 busy", busy, 0);
    check_mem("R1 init");

    // R2, R7 sweep of every address
    for (int a = 0; a < N; a++) run(2'b11, AW'(a), 9, 0, "R2/R7 word");

    // R3, R4 opcode and upper-address sweep
    for (int op = 0; op < 3; op++)
      for (int hb = 0; hb < 4; hb++) begin
        do_reset();
        run(2'(op), AW'((hb << 4) | 5), 9, 0,
            (op == 0 && hb == 2) ? "R3 all" : "R4 ignored");
      end

    // R5 cancel before each edge count
    do_reset();
    for (int n = 1; n < 9; n++) run(2'b11, AW'(9), n, 0, "R5 cancel");

    // R5 ninth edge and select fall in the same cycle
    busy_cnt = 0;
    cs_on();
    frame(2'b11, AW'(12), 8);
    di = 0;
    settle(H);
    sk = 1; cs = 0;
    settle(H);
    sk = 0;
    settle(EC + 30);
    check(busy_cnt == 0, "R5 same-cycle busy", busy_cnt, 0);
    check_mem("R5 same-cycle mem");

    // R6 extra pulses after commit
    run(2'b11, AW'(20), 9, 5, "R6 extra pulses");

    // R8 frame during busy
    do_reset();
    cs_on();
    frame(2'b11, AW'(7), 9);
    cs_off();
    settle(6);
    cs_on();
    frame(2'b11, AW'(8), 9);
    cs_off();
    settle(EC + 40);
    model[7] = '1;
    check(busy_cnt == EC, "R8 single busy", busy_cnt, EC);
    check_mem("R8 mem");

    // R9 clock and data high when select rises
    do_reset();
    sk = 1; di = 1;
    settle(H);
    cs = 1;
    settle(2 * H);
    sk = 0;
    settle(H);
    pulse(1); pulse(1);
    for (int k = 5; k >= 0; k--) pulse(k[0]);
    cs_off();
    settle(EC + 30);
    check(busy_cnt == 0, "R9 busy", busy_cnt, 0);
    check_mem("R9 mem");

    // R10 leading zeros
    busy_cnt = 0;
    cs_on();
    pulse(0); pulse(0); pulse(0);
    frame(2'b11, AW'(33), 9);
    cs_off();
    settle(EC + 30);
    model[33] = '1;
    check(busy_cnt == EC, "R10 busy", busy_cnt, EC);
    check_mem("R10 mem");

    // R11 standby
    busy_cnt = 0;
    frame(2'b00, AW'(6'h20), 9);
    frame(2'b11, AW'(40), 9);
    settle(EC + 30);
    check(busy_cnt == 0, "R11 busy", busy_cnt, 0);
    check_mem("R11 mem");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule